// File: doc/BRIEF.md
# Power Management Wake Event Controller

This block gathers wake events from two ring-indicator inputs and a set of general-purpose pins, then drives a single wake request pin towards the chipset. Every source has a sticky status bit, set by a qualifying edge, and an individual enable bit. A source can raise the request only when its status and its enable bit are both set and the global enable is on. Software clears a status bit by writing a one to it.

All inputs pass through a two-flop synchroniser before edge detection. General-purpose pins take their edge direction from a per-pin invert input. A low-to-high edge counts when the invert bit is 0, and a high-to-low edge counts when it is 1. Ring inputs idle high, and only their high-to-low transition counts. The output pin can be active-low or active-high. It can also be open-drain, which drives only the active level, or push-pull. An external decoder maps the byte-wide register port into the system address space.

Top module: `wake_evt_ctrl`

## Requirements
- R1: The request is active only while the global enable (control register bit 4) is 1 and at least one source has both its status bit and its enable bit at 1.
- R2: A qualifying edge sets the status bit of its source whether or not the global enable is on. The bit is readable on the third rising clock edge after the input changes.
- R3: Writing a 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R4: Bit 7 of the ring status register (address 6) reads the summary bit, the OR over all sources of status AND enable. It drops only when every enabled pending status bit has been cleared.
- R5: A general-purpose pin with its invert input at 0 sets status on a low-to-high edge and ignores the falling edge. With the invert input at 1 it sets status on a high-to-low edge and ignores the rising edge.
- R6: A ring input sets its status (address 6 bits 1:0, bit 0 = ring 0) on a high-to-low transition. A low-to-high transition has no effect.
- R7: Control bit 5 selects the output polarity: 0 gives active-low (the reset value) and 1 gives active-high. The pin carries the active level while the request is active and the opposite level otherwise.
- R8: Control bit 6 selects push-pull when 1. With the reset value 0 the output is open-drain, and its output enable is high only while the request is active.
- R9: If a source edge and a write-one-to-clear reach the same status bit in the same cycle, the status bit stays set.
- R10: After reset all status bits, all enables and all control bits are 0. The output enable is then low and the pin value is high.
- R11: Register map, 3-bit address, 8-bit data. Addresses 0/2/4 hold the status of pins 0-7, 8-15 and 16-23, and addresses 1/3/5 hold the matching enables. Address 6 holds the ring status. Address 7 is the control register: bits 1:0 are the ring enables, bit 4 is the global enable, bit 5 selects polarity and bit 6 selects push-pull. Enable and control bits read back as written, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_i | input | 24 | General-purpose wake inputs (asynchronous) |
| gpio_inv_i | input | 24 | Per-pin edge select: 0 rising, 1 falling |
| ring_i | input | 2 | Ring-indicator inputs, idle high (asynchronous) |
| wr_en_i | input | 1 | Register write strobe, captured on the clock edge |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| wake_o | output | 1 | Wake pin value |
| wake_oe_o | output | 1 | Wake pin output enable |

## Verification
The wake sources are driven with single rising edges, single falling edges, rise-then-fall pairs and ring pulses, under both invert settings. These patterns show whether edge direction, and not input level, is what latches status. The same pending event is viewed with the individual enable off, then with only the global enable off, then with both on. This separates the gating of the summary bit from the gating of the pin. A clear write is placed on exactly the cycle a new edge lands, which separates set priority from clear priority. Each combination of polarity and driver mode is exercised, showing how the pin value and the output enable follow the request.

// File: rtl/wake_evt_pkg.sv
package wake_evt_pkg;
  localparam int CTL_GLOB_BIT = 4;
  localparam int CTL_HI_BIT   = 5;
  localparam int CTL_PP_BIT   = 6;

  typedef struct packed {
    logic push_pull;
    logic act_hi;
    logic glob_en;
  } wake_ctl_t;
endpackage

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic [W-1:0] inv,
  output logic [W-1:0] evt
);
  logic [W-1:0] s1_q, s2_q, prev_q;
  logic [W-1:0] s1_d, s2_d, prev_d;

  always_comb begin
    s1_d   = din;
    s2_d   = s1_q;
    prev_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= RST_VAL;
      s2_q   <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      prev_q <= prev_d;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign evt[i] = inv[i] ? (prev_q[i] & ~s2_q[i]) : (s2_q[i] & ~prev_q[i]);
  end
endmodule

// File: rtl/wake_status_bank.sv
module wake_status_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] st_q, st_d;

  always_comb st_d = (st_q & ~clr_i) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign status_o = st_q;
endmodule

// File: rtl/wake_pad_drv.sv
module wake_pad_drv (
  input  logic req,
  input  logic act_hi,
  input  logic push_pull,
  output logic pad_o,
  output logic pad_oe
);
  always_comb begin
    pad_o  = req ? act_hi : ~act_hi;
    pad_oe = push_pull | req;
  end
endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
  import wake_evt_pkg::*;
#(
  parameter int GPIO_GROUPS = 3,
  parameter int GROUP_W     = 8,
  parameter int RING_N      = 2,
  localparam int GPIO_N     = GPIO_GROUPS * GROUP_W,
  localparam int NREG       = 2 * GPIO_GROUPS + 2,
  localparam int ADDR_W     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GPIO_N-1:0] gpio_i,
  input  logic [GPIO_N-1:0] gpio_inv_i,
  input  logic [RING_N-1:0] ring_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [GROUP_W-1:0] wdata_i,
  output logic [GROUP_W-1:0] rdata_o,
  output logic              wake_o,
  output logic              wake_oe_o
);
  localparam int N_SRC    = GPIO_N + RING_N;
  localparam int RS_ADDR  = 2 * GPIO_GROUPS;
  localparam int CTL_ADDR = RS_ADDR + 1;
  localparam logic [N_SRC-1:0] SYNC_RST = {{RING_N{1'b1}}, {GPIO_N{1'b0}}};
  localparam logic [N_SRC-1:0] SRC_INV_FIX = {{RING_N{1'b1}}, {GPIO_N{1'b0}}};

  logic [N_SRC-1:0] src_evt, clr_vec, status_q, en_q, en_d;
  wake_ctl_t        ctl_q, ctl_d;
  logic             summary, wake_req;

  wake_edge_det #(.W(N_SRC), .RST_VAL(SYNC_RST)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({ring_i, gpio_i}),
    .inv   (SRC_INV_FIX | {{RING_N{1'b0}}, gpio_inv_i}),
    .evt   (src_evt)
  );

  // write-one-to-clear masks
  always_comb begin
    clr_vec = '0;
    if (wr_en_i) begin
      for (int g = 0; g < GPIO_GROUPS; g++) begin
        if (addr_i == ADDR_W'(2 * g)) clr_vec[g*GROUP_W +: GROUP_W] = wdata_i;
      end
      if (addr_i == ADDR_W'(RS_ADDR)) clr_vec[GPIO_N +: RING_N] = wdata_i[RING_N-1:0];
    end
  end

  wake_status_bank #(.W(N_SRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (src_evt),
    .clr_i    (clr_vec),
    .status_o (status_q)
  );

  // enable and control next state
  always_comb begin
    en_d  = en_q;
    ctl_d = ctl_q;
    if (wr_en_i) begin
      for (int g = 0; g < GPIO_GROUPS; g++) begin
        if (addr_i == ADDR_W'(2 * g + 1)) en_d[g*GROUP_W +: GROUP_W] = wdata_i;
      end
      if (addr_i == ADDR_W'(CTL_ADDR)) begin
        en_d[GPIO_N +: RING_N] = wdata_i[RING_N-1:0];
        ctl_d.glob_en   = wdata_i[CTL_GLOB_BIT];
        ctl_d.act_hi    = wdata_i[CTL_HI_BIT];
        ctl_d.push_pull = wdata_i[CTL_PP_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ctl_q <= '0;
    end else begin
      en_q  <= en_d;
      ctl_q <= ctl_d;
    end
  end

  assign summary  = |(status_q & en_q);
  assign wake_req = ctl_q.glob_en & summary;

  // read mux
  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < GPIO_GROUPS; g++) begin
      if (addr_i == ADDR_W'(2 * g))     rdata_o = status_q[g*GROUP_W +: GROUP_W];
      if (addr_i == ADDR_W'(2 * g + 1)) rdata_o = en_q[g*GROUP_W +: GROUP_W];
    end
    if (addr_i == ADDR_W'(RS_ADDR)) begin
      rdata_o[RING_N-1:0] = status_q[GPIO_N +: RING_N];
      rdata_o[GROUP_W-1]  = summary;
    end
    if (addr_i == ADDR_W'(CTL_ADDR)) begin
      rdata_o[RING_N-1:0]  = en_q[GPIO_N +: RING_N];
      rdata_o[CTL_GLOB_BIT] = ctl_q.glob_en;
      rdata_o[CTL_HI_BIT]   = ctl_q.act_hi;
      rdata_o[CTL_PP_BIT]   = ctl_q.push_pull;
    end
  end

  wake_pad_drv u_pad (
    .req       (wake_req),
    .act_hi    (ctl_q.act_hi),
    .push_pull (ctl_q.push_pull),
    .pad_o     (wake_o),
    .pad_oe    (wake_oe_o)
  );
endmodule

// File: rtl/wake_evt_chk.sv
module wake_evt_chk #(
  parameter int N = 26
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] status,
  input logic [N-1:0] set_v,
  input logic [N-1:0] clr,
  input logic         glob_en,
  input logic         act_hi,
  input logic         push_pull,
  input logic         req,
  input logic         pad_o,
  input logic         pad_oe
);
  // R1
  glob_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> !req);

  // R3
  w1c_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status & $past(status) & ~$past(clr)) == '0));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((status & $past(set_v)) == $past(set_v)));

  // R8
  pp_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_pull |-> pad_oe);

  // R8
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_pull && !req) |-> !pad_oe);

  // R7
  level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> (pad_o == (req ? act_hi : !act_hi)));
endmodule

bind wake_evt_ctrl wake_evt_chk #(.N(N_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .status    (status_q),
  .set_v     (src_evt),
  .clr       (clr_vec),
  .glob_en   (ctl_q.glob_en),
  .act_hi    (ctl_q.act_hi),
  .push_pull (ctl_q.push_pull),
  .req       (wake_req),
  .pad_o     (wake_o),
  .pad_oe    (wake_oe_o)
);

// File: tb/wake_evt_ctrl_test.sv
module wake_evt_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] gpio_i = '0;
  logic [23:0] gpio_inv_i = '0;
  logic [1:0]  ring_i = 2'b11;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        wake_o, wake_oe_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  wake_evt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .gpio_i(gpio_i), .gpio_inv_i(gpio_inv_i),
    .ring_i(ring_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .wake_o(wake_o), .wake_oe_o(wake_oe_o)
  );

  // behavioural reference model
  localparam logic [25:0] IDLE_IN = {2'b11, 24'h0};
  logic [25:0] hist[$];
  logic [25:0] m_st, m_en;
  logic        m_glob, m_hi, m_pp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {IDLE_IN, IDLE_IN, IDLE_IN, IDLE_IN};
      m_st = '0; m_en = '0; m_glob = 0; m_hi = 0; m_pp = 0;
    end else begin
      logic [25:0] ev, clr, cur, pv;
      hist.push_front({ring_i, gpio_i});
      cur = hist[2];
      pv  = hist[3];
      void'(hist.pop_back());
      for (int i = 0; i < 26; i++) begin
        logic falling;
        falling = (i >= 24) ? 1'b1 : gpio_inv_i[i];
        ev[i] = falling ? (pv[i] && !cur[i]) : (cur[i] && !pv[i]);
      end
      clr = '0;
      if (wr_en_i) begin
        case (addr_i)
          3'd0: clr[7:0]   = wdata_i;
          3'd2: clr[15:8]  = wdata_i;
          3'd4: clr[23:16] = wdata_i;
          3'd6: clr[25:24] = wdata_i[1:0];
          3'd1: m_en[7:0]   = wdata_i;
          3'd3: m_en[15:8]  = wdata_i;
          3'd5: m_en[23:16] = wdata_i;
          3'd7: begin
            m_en[25:24] = wdata_i[1:0];
            m_glob = wdata_i[4]; m_hi = wdata_i[5]; m_pp = wdata_i[6];
          end
          default: ;
        endcase
      end
      m_st = (m_st & ~clr) | ev;
    end
  end

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_st[7:0];
      3'd1: return m_en[7:0];
      3'd2: return m_st[15:8];
      3'd3: return m_en[15:8];
      3'd4: return m_st[23:16];
      3'd5: return m_en[23:16];
      3'd6: return {|(m_st & m_en), 5'b0, m_st[25:24]};
      default: return {1'b0, m_pp, m_hi, m_glob, 2'b0, m_en[25:24]};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // pin comparison every clock (R1, R7, R8)
  always @(negedge clk) begin
    if (rst_n) begin
      logic req;
      req = m_glob && |(m_st & m_en);
      chk("R1/R7 wake_o", {7'b0, wake_o}, {7'b0, req ? m_hi : !m_hi});
      chk("R1/R8 wake_oe", {7'b0, wake_oe_o}, {7'b0, m_pp || req});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr_i = a;
    #1;
    chk(tag, rdata_o, exp);
    chk({tag, " model"}, rdata_o, m_read(a));
  endtask

  task automatic run_tests();
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R10 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, "R10 reset reg");
    chk("R10 oe idle", {7'b0, wake_oe_o}, 8'h00);
    chk("R10 pin idle", {7'b0, wake_o}, 8'h01);

    // R2: edge sets status with global enable off
    @(negedge clk); gpio_i[3] = 1'b1;
    cyc(4);
    rd(3'd0, 8'h08, "R2 status set");
    rd(3'd6, 8'h00, "R4 summary needs enable");
    wr(3'd1, 8'h08);
    rd(3'd6, 8'h80, "R4 summary set");
    chk("R1 no request without global", {7'b0, wake_oe_o}, 8'h00);
    wr(3'd7, 8'h10);
    cyc(1);
    chk("R1 request active", {7'b0, wake_oe_o}, 8'h01);
    chk("R7 active low", {7'b0, wake_o}, 8'h00);

    // R3 write zero / other bits has no effect
    wr(3'd0, 8'h00);
    rd(3'd0, 8'h08, "R3 zero write");
    wr(3'd0, 8'hF7);
    rd(3'd0, 8'h08, "R3 other bits");
    wr(3'd0, 8'h08);
    rd(3'd0, 8'h00, "R3 clear");
    rd(3'd6, 8'h00, "R4 summary cleared");
    chk("R1 released", {7'b0, wake_oe_o}, 8'h00);

    // R5 inverted polarity on pin 12
    gpio_inv_i[12] = 1'b1;
    cyc(2);
    gpio_i[12] = 1'b1;
    cyc(5);
    rd(3'd2, 8'h00, "R5 inverted ignores rise");
    gpio_i[12] = 1'b0;
    cyc(5);
    rd(3'd2, 8'h10, "R5 inverted falling sets");
    // R5 non-inverted pin 20: rise sets, fall ignored
    gpio_i[20] = 1'b1;
    cyc(5);
    rd(3'd4, 8'h10, "R5 rising sets");
    wr(3'd4, 8'h10);
    gpio_i[20] = 1'b0;
    cyc(5);
    rd(3'd4, 8'h00, "R5 falling ignored");

    // R6 ring input
    ring_i[0] = 1'b0;
    cyc(5);
    rd(3'd6, 8'h01, "R6 ring fall sets");
    wr(3'd6, 8'h01);
    ring_i[0] = 1'b1;
    cyc(5);
    rd(3'd6, 8'h00, "R6 ring rise ignored");

    // R7 active-high with ring enable
    wr(3'd7, 8'h31);
    rd(3'd7, 8'h31, "R11 ctrl readback");
    ring_i[0] = 1'b0;
    cyc(5);
    chk("R7 active high level", {7'b0, wake_o}, 8'h01);
    chk("R8 od drives active", {7'b0, wake_oe_o}, 8'h01);
    wr(3'd7, 8'h71);
    wr(3'd6, 8'h01);
    cyc(1);
    chk("R8 push-pull idle oe", {7'b0, wake_oe_o}, 8'h01);
    chk("R8 push-pull idle level", {7'b0, wake_o}, 8'h00);
    ring_i[0] = 1'b1;

    // R9 edge and clear in the same cycle
    gpio_i[0] = 1'b1;
    cyc(5);
    rd(3'd0, 8'h01, "R9 preset");
    gpio_i[0] = 1'b0;
    cyc(5);
    @(negedge clk); gpio_i[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en_i = 1'b1; addr_i = 3'd0; wdata_i = 8'h01;
    @(negedge clk); wr_en_i = 1'b0;
    rd(3'd0, 8'h01, "R9 set wins");
    wr(3'd0, 8'h01);
    rd(3'd0, 8'h00, "R9 later clear");

    // R11 register map
    wr(3'd3, 8'hA5);
    wr(3'd5, 8'h3C);
    rd(3'd3, 8'hA5, "R11 enable 1");
    rd(3'd5, 8'h3C, "R11 enable 2");
    rd(3'd1, 8'h08, "R11 enable 0");
    wr(3'd7, 8'hFF);
    rd(3'd7, 8'h73, "R11 ctrl unused bits");

    // R4 summary stays while one enabled source pending
    gpio_i[10] = 1'b1; gpio_i[18] = 1'b1;
    cyc(5);
    rd(3'd6, 8'h80, "R4 two pending");
    wr(3'd2, 8'h04);
    rd(3'd6, 8'h80, "R4 one still pending");
    wr(3'd4, 8'h04);
    rd(3'd6, 8'h00, "R4 all cleared");
    cyc(3);
  endtask

  initial begin
    fork
      run_tests();
      begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule